// File: doc/BRIEF.md
# I2C Target Address Matcher (7-bit and 10-bit)

This block sits on the target side of a two-wire serial bus. It decides whether an address phase selects this device. A bit-level front end feeds it byte events: a start pulse with a flag that marks a repeated start, a strobe for each received byte together with its data, and a stop pulse. Software sets the own address, a mode bit that picks 7-bit or 10-bit addressing, and an enable.

For each address byte that selects the device, the block raises a one-cycle acknowledge request. It holds a match flag and the transfer direction until the next start or stop. In 10-bit mode the device is selected only after both header bytes agree. A read in 10-bit mode is reached through a repeated start that carries only the first header byte with the read bit set. That read is accepted only after a full write-direction match in the same transaction.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match flag and acknowledge request are both 0.
- R2: In 7-bit mode with enable set, a first byte after a start whose bits [7:1] equal the own address bits [6:0] gives, one cycle after the strobe, an acknowledge pulse and a match flag. The direction output is the byte's bit 0, where 0 means write and 1 means read.
- R3: In 7-bit mode an own address below 0x08 or above 0x77 never matches.
- R4: In 7-bit mode a first byte whose bits [7:3] are 11110 never matches.
- R5: In 10-bit mode a first byte of 11110, then own address bits [9:8], then 0 is acknowledged. The match flag stays 0 after it.
- R6: In 10-bit mode, after an acknowledged write header, a second byte equal to own address bits [7:0] is acknowledged and sets the match flag with direction write. Any other second byte gives neither.
- R7: After a full 10-bit write match, a repeated start followed by the same header with bit 0 set is acknowledged. It sets the match flag with direction read, and no further address byte is needed.
- R8: A 10-bit read header after a plain start, with no full write match since that start, is not acknowledged. A stop also discards an earlier full match.
- R9: A first byte that does not match leaves the match flag at 0 and is not acknowledged. Every further byte up to the next start is also ignored.
- R10: With enable cleared, no byte is acknowledged and no match occurs.
- R11: A stop or a start clears the match flag one cycle after its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Address matching enable |
| cfg_ten | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| cfg_addr | input | 10 | Own address (7-bit mode uses bits [6:0]) |
| ev_start | input | 1 | Start condition pulse |
| ev_rstart | input | 1 | Qualifies ev_start as a repeated start |
| ev_byte | input | 1 | Received byte strobe |
| ev_data | input | 8 | Received byte, bit 7 first on the wire |
| ev_stop | input | 1 | Stop condition pulse |
| ack_req | output | 1 | One-cycle request to drive ACK for the byte just received |
| hit | output | 1 | Device is addressed |
| rd_nwr | output | 1 | Direction of the addressed transfer: 1 read, 0 write |

## Verification
The acknowledge pulse, the match flag and the direction all come from one register stage. Each is due in the cycle that follows the strobe of the byte that decides it. A start or stop pulse clears the flag in the cycle after the pulse.

The bench drives every event on a falling edge for exactly one cycle. It samples at the next falling edge, when the pulse from the registered stage is high. A missing acknowledge is therefore seen in the same cycle where a present one would be. Checks that a byte is ignored sample the acknowledge and the flag after that byte and before the next event.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int SEV_W  = 7;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_LOW   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   armed;
        logic   hit;
        logic   rd;
        logic   ack;
    } am_state_t;
endpackage

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
    import i2c_am_pkg::*;
#(
    parameter logic [SEV_W-1:0] LO_LIMIT = 7'h08,
    parameter logic [SEV_W-1:0] HI_LIMIT = 7'h77
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] own,
    input  logic [BYTE_W-1:0] rx,
    output logic              m_sev,
    output logic              m_hdr,
    output logic              m_low
);
    logic own_ok;
    logic is_pfx;

    always_comb begin
        own_ok = (own[SEV_W-1:0] >= LO_LIMIT) && (own[SEV_W-1:0] <= HI_LIMIT);
        is_pfx = (rx[BYTE_W-1:3] == TEN_PREFIX);
        m_sev  = en && own_ok && !is_pfx && (rx[BYTE_W-1:1] == own[SEV_W-1:0]);
        m_hdr  = en && is_pfx && (rx[2:1] == own[ADDR_W-1:BYTE_W]);
        m_low  = en && (rx == own[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ten,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_byte,
    input  logic              ev_stop,
    input  logic [BYTE_W-1:0] ev_data,
    input  logic              m_sev,
    input  logic              m_hdr,
    input  logic              m_low,
    output logic              ack_req,
    output logic              hit,
    output logic              rd_nwr
);
    am_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (ev_stop) begin
            st_d.phase = PH_IDLE;
            st_d.hit   = 1'b0;
            st_d.armed = 1'b0;
        end else if (ev_start) begin
            st_d.phase = PH_FIRST;
            st_d.hit   = 1'b0;
            if (!ev_rstart) st_d.armed = 1'b0;
        end else if (ev_byte) begin
            case (st_q.phase)
                PH_FIRST: begin
                    st_d.phase = PH_IDLE;
                    st_d.armed = 1'b0;
                    if (!ten) begin
                        if (m_sev) begin
                            st_d.hit = 1'b1;
                            st_d.rd  = ev_data[0];
                            st_d.ack = 1'b1;
                        end
                    end else if (m_hdr) begin
                        if (!ev_data[0]) begin
                            st_d.phase = PH_LOW;
                            st_d.rd    = 1'b0;
                            st_d.ack   = 1'b1;
                        end else if (st_q.armed) begin
                            st_d.hit   = 1'b1;
                            st_d.rd    = 1'b1;
                            st_d.ack   = 1'b1;
                            st_d.armed = 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    st_d.phase = PH_IDLE;
                    if (m_low) begin
                        st_d.hit   = 1'b1;
                        st_d.rd    = 1'b0;
                        st_d.ack   = 1'b1;
                        st_d.armed = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, armed: 1'b0, hit: 1'b0, rd: 1'b0, ack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_req = st_q.ack;
    assign hit     = st_q.hit;
    assign rd_nwr  = st_q.rd;

    // R11: stop clears the match flag
    a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !hit);
    // R4: prefix bytes never match in 7-bit mode
    a_r4_no_prefix_sev: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte && !ev_start && !ev_stop && !ten && st_q.phase == PH_FIRST
         && ev_data[7:3] == TEN_PREFIX) |=> !ack_req);
    // R9: acknowledge only follows a byte strobe
    a_r9_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> $past(ev_byte));
    // R5: a 10-bit write header alone never selects the device
    a_r5_hdr_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LOW) |-> !hit);
    // R2: direction of a 7-bit match follows bit 0 of the byte
    a_r2_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hit) && !$past(ten)) |-> (rd_nwr == $past(ev_data[0])));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter logic [SEV_W-1:0] LO_LIMIT = 7'h08,
    parameter logic [SEV_W-1:0] HI_LIMIT = 7'h77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_ten,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_byte,
    input  logic [BYTE_W-1:0] ev_data,
    input  logic              ev_stop,
    output logic              ack_req,
    output logic              hit,
    output logic              rd_nwr
);
    logic m_sev, m_hdr, m_low;

    i2c_am_decode #(.LO_LIMIT(LO_LIMIT), .HI_LIMIT(HI_LIMIT)) u_dec (
        .en    (cfg_en),
        .own   (cfg_addr),
        .rx    (ev_data),
        .m_sev (m_sev),
        .m_hdr (m_hdr),
        .m_low (m_low)
    );

    i2c_am_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ten       (cfg_ten),
        .ev_start  (ev_start),
        .ev_rstart (ev_rstart),
        .ev_byte   (ev_byte),
        .ev_stop   (ev_stop),
        .ev_data   (ev_data),
        .m_sev     (m_sev),
        .m_hdr     (m_hdr),
        .m_low     (m_low),
        .ack_req   (ack_req),
        .hit       (hit),
        .rd_nwr    (rd_nwr)
    );

    // R10: nothing is acknowledged while disabled
    a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte && !cfg_en) |=> !ack_req);
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b1, cfg_ten = 1'b0;
    logic [9:0] cfg_addr = 10'h03C;
    logic       ev_start = 1'b0, ev_rstart = 1'b0, ev_byte = 1'b0, ev_stop = 1'b0;
    logic [7:0] ev_data = 8'h00;
    logic       ack_req, hit, rd_nwr;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    i2c_addr_match dut (.*);

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic rep);
        @(negedge clk); ev_start = 1'b1; ev_rstart = rep;
        @(negedge clk); ev_start = 1'b0; ev_rstart = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); ev_byte = 1'b1; ev_data = b;
        @(negedge clk); ev_byte = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ack", ack_req, 1'b0);
        chk("R1 hit", hit, 1'b0);
    endtask

    task automatic t_sev_hit();
        cfg_ten = 1'b0; cfg_addr = 10'h03C;
        do_start(1'b0); do_byte(8'h78);
        chk("R2 write ack", ack_req, 1'b1);
        chk("R2 write hit", hit, 1'b1);
        chk("R2 write dir", rd_nwr, 1'b0);
        do_start(1'b1);
        chk("R11 start clears hit", hit, 1'b0);
        do_byte(8'h79);
        chk("R2 read ack", ack_req, 1'b1);
        chk("R2 read dir", rd_nwr, 1'b1);
        do_stop();
        chk("R11 stop clears hit", hit, 1'b0);
    endtask

    task automatic t_sev_miss();
        cfg_ten = 1'b0; cfg_addr = 10'h03C;
        do_start(1'b0); do_byte(8'h7A);
        chk("R9 miss ack", ack_req, 1'b0);
        chk("R9 miss hit", hit, 1'b0);
        do_byte(8'h78);
        chk("R9 later byte ignored ack", ack_req, 1'b0);
        chk("R9 later byte ignored hit", hit, 1'b0);
        do_stop();
    endtask

    task automatic t_reserved();
        cfg_ten = 1'b0; cfg_addr = 10'h005;
        do_start(1'b0); do_byte(8'h0A);
        chk("R3 low reserved ack", ack_req, 1'b0);
        do_stop();
        cfg_addr = 10'h07B;
        do_start(1'b0); do_byte(8'hF6);
        chk("R4 prefix ack", ack_req, 1'b0);
        chk("R3 high reserved hit", hit, 1'b0);
        do_stop();
        cfg_addr = 10'h008;
        do_start(1'b0); do_byte(8'h10);
        chk("R3 lowest valid ack", ack_req, 1'b1);
        do_stop();
    endtask

    task automatic t_ten_write();
        cfg_ten = 1'b1; cfg_addr = 10'h2A5;
        do_start(1'b0); do_byte(8'hF4);
        chk("R5 header ack", ack_req, 1'b1);
        chk("R5 header no hit", hit, 1'b0);
        do_byte(8'hA5);
        chk("R6 low ack", ack_req, 1'b1);
        chk("R6 hit", hit, 1'b1);
        chk("R6 dir", rd_nwr, 1'b0);
        do_start(1'b1); do_byte(8'hF5);
        chk("R7 read ack", ack_req, 1'b1);
        chk("R7 read hit", hit, 1'b1);
        chk("R7 read dir", rd_nwr, 1'b1);
        do_stop();
        do_start(1'b0); do_byte(8'hF5);
        chk("R8 read after stop ack", ack_req, 1'b0);
        chk("R8 read after stop hit", hit, 1'b0);
        do_stop();
    endtask

    task automatic t_ten_miss();
        cfg_ten = 1'b1; cfg_addr = 10'h2A5;
        do_start(1'b0); do_byte(8'hF2);
        chk("R9 header miss ack", ack_req, 1'b0);
        do_byte(8'hA5);
        chk("R9 low after header miss", ack_req, 1'b0);
        do_stop();
        do_start(1'b0); do_byte(8'hF4); do_byte(8'hA4);
        chk("R6 low miss ack", ack_req, 1'b0);
        chk("R6 low miss hit", hit, 1'b0);
        do_start(1'b1); do_byte(8'hF5);
        chk("R8 read unarmed ack", ack_req, 1'b0);
        do_stop();
    endtask

    task automatic t_disabled();
        cfg_ten = 1'b0; cfg_addr = 10'h03C; cfg_en = 1'b0;
        do_start(1'b0); do_byte(8'h78);
        chk("R10 disabled ack", ack_req, 1'b0);
        chk("R10 disabled hit", hit, 1'b0);
        do_stop();
        cfg_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sev_hit();
        t_sev_miss();
        t_reserved();
        t_ten_write();
        t_ten_miss();
        t_disabled();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule